// File: doc/BRIEF.md
# Interrupt Status and Enable Register Bank

This block holds the per-source interrupt state of one peripheral. It has a status register that records interrupt events from the peripheral's internal logic, and an enable register that selects which recorded events may interrupt the processor. The number of implemented sources, `NUM_IRQ`, is a parameter from 0 to 32. Source bits occupy positions 0 upward. Every position at or above `NUM_IRQ` is absent: it reads as 0 and ignores writes. With `NUM_IRQ = 0` both registers are absent.

Software reaches the bank through a flat word-addressed port with a write strobe, address, write data and combinational read data. The register map is:

| Word address | Register |
|---|---|
| 0 | status |
| 1 | enable |
| 2 | software reset (write only) |

A write to the status register flips each selected bit. The same write issued twice therefore first raises a bit and then acknowledges it. A hardware event on `irq_src` sets its status bit and keeps it set. When a hardware event and a flip hit the same bit in the same cycle, the hardware event wins.

The bank forms one registered interrupt line from status AND enable for the device-level stage above it. Writing the unlock key to the software-reset word puts the bank back into its power-up state. In that state every interrupt is disabled.

Top module: `irq_reg_bank`

## Requirements
- R1: After a hardware reset (rst_n low at a clock edge) the enable register, at word address 1, reads 0.
- R2: After any reset the status register, at word address 0, reads `STATUS_RST` masked to the implemented bits. The default is 0x5, so bits 0 and 2 read 1.
- R3: A write to word address 0 inverts every implemented status bit whose write-data bit is 1 and leaves the other bits unchanged. Two identical writes therefore return the register to its previous value.
- R4: A 1 on `irq_src[i]` at a clock edge sets status bit i. The bit stays 1 after the input returns to 0. A simultaneous flip of that bit still leaves it at 1.
- R5: A write to word address 1 stores the write data in the implemented enable bits, and the register reads back exactly that value, including 0.
- R6: `irq_out` is a register. After each clock edge it equals the OR over all bits of (status AND enable) as they stood before that edge, so it rises and falls one cycle after its cause.
- R7: Bit positions at or above `NUM_IRQ` read 0 in both registers and are unaffected by writes.
- R8: A write of `SWRST_KEY` (default 0xA5) to word address 2 returns status to its reset value, clears enable and clears `irq_out` at the same edge. A hardware event in that cycle is discarded. A write of any other value to word address 2 has no effect.
- R9: Reads from any other word address return 0, and writes to such an address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_src | input | max(NUM_IRQ,1) | Per-source interrupt events, active high |
| irq_out | output | 1 | Registered aggregated interrupt |

## Verification
The status and enable registers are both visible through a combinational read path, so a corrupted bit shows in `bus_rdata` in the same cycle that software addresses it. A wrong aggregation term, or an interrupt flop that skips or adds a pipeline stage, shows on `irq_out` exactly one edge after the cause. The bench samples this output on the falling edge just before that edge and again just after it. A soft reset that clears too little, or a flip that is taken for a set, leaves a stale bit that the next read-back exposes.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
// Package: shared register-map constants and mask helper for the interrupt bank.
// Assumes word addressing; offsets are small integers that fit any ADDR_W >= 2.
package irq_bank_pkg;

    localparam int OFS_STATUS = 0;
    localparam int OFS_ENABLE = 1;
    localparam int OFS_SWRST  = 2;

    // Selected register for a bus access.
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_SWRST  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Mask with the low n bits set, n in 0..32.
    function automatic logic [31:0] low_mask(input int n);
        logic [31:0] m;
        m = '0;
        for (int k = 0; k < 32; k++) begin
            if (k < n) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
`timescale 1ns/1ps
// Module: irq_bus_decode
// Turns the flat word bus into a register select and one-cycle write
// strobes. The software reset fires only on an exact key match.
// Assumes bus_addr is stable while bus_we is high at the edge.
module irq_bus_decode
    import irq_bank_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] SWRST_KEY = 32'h0000_00A5
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output reg_sel_e          sel,
    output logic              wr_status,
    output logic              wr_enable,
    output logic              soft_rst
);

    localparam logic [DATA_W-1:0] KEY = DATA_W'(SWRST_KEY);

    // Address to register select.
    always_comb begin
        if (bus_addr == ADDR_W'(OFS_STATUS))      sel = SEL_STATUS;
        else if (bus_addr == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
        else if (bus_addr == ADDR_W'(OFS_SWRST))  sel = SEL_SWRST;
        else                                      sel = SEL_NONE;
    end

    // Write strobes, qualified by the select.
    always_comb begin
        wr_status = bus_we && (sel == SEL_STATUS);
        wr_enable = bus_we && (sel == SEL_ENABLE);
        soft_rst  = bus_we && (sel == SEL_SWRST) && (bus_wdata == KEY);
    end

endmodule

// File: rtl/irq_status_reg.sv
`timescale 1ns/1ps
// Module: irq_status_reg
// Per-bit interrupt status. A software write flips the selected bits and a
// hardware event sets its bit; the hardware set wins a same-cycle clash.
// Positions at or above NUM_IRQ are not built and read 0.
// Assumes soft_rst is a one-cycle strobe from the decoder.
module irq_status_reg #(
    parameter int          NUM_IRQ = 12,
    parameter int          W       = 12,
    parameter logic [31:0] RST_VAL = 32'h0000_0005
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] src,
    output logic [W-1:0] status
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < NUM_IRQ) begin : g_impl
            logic bit_q;
            // Reset to the IP default, else flip on write and set on event.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst) bit_q <= RST_VAL[i];
                else                    bit_q <= (bit_q ^ (wr & wdata[i])) | src[i];
            end
            assign status[i] = bit_q;
        end else begin : g_absent
            assign status[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_enable_reg.sv
`timescale 1ns/1ps
// Module: irq_enable_reg
// Plain read/write enable bits, cleared by either reset.
// Positions at or above NUM_IRQ are not built and read 0.
module irq_enable_reg #(
    parameter int NUM_IRQ = 12,
    parameter int W       = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] enable
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < NUM_IRQ) begin : g_impl
            logic bit_q;
            // Clear on reset, load on write, otherwise hold.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst) bit_q <= 1'b0;
                else if (wr)            bit_q <= wdata[i];
            end
            assign enable[i] = bit_q;
        end else begin : g_absent
            assign enable[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_combine.sv
`timescale 1ns/1ps
// Module: irq_combine
// Registers the OR of status AND enable into one interrupt line, so the
// line follows its cause by exactly one edge. Cleared by either reset.
module irq_combine #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] status,
    input  logic [W-1:0] enable,
    output logic         irq_q
);

    // One flop after the reduction keeps the output glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) irq_q <= 1'b0;
        else                    irq_q <= |(status & enable);
    end

endmodule

// File: rtl/irq_reg_bank.sv
`timescale 1ns/1ps
// Module: irq_reg_bank (top)
// Interrupt status/enable bank with a flip-on-write status register, a
// software reset word and a registered aggregated interrupt output.
// Assumes NUM_IRQ <= DATA_W <= 32 and ADDR_W >= 2.
module irq_reg_bank
    import irq_bank_pkg::*;
#(
    parameter int          NUM_IRQ    = 12,
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 4,
    parameter logic [31:0] STATUS_RST = 32'h0000_0005,
    parameter logic [31:0] SWRST_KEY  = 32'h0000_00A5,
    localparam int         SRC_W      = (NUM_IRQ > 0) ? NUM_IRQ : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SRC_W-1:0]  irq_src,
    output logic              irq_out
);

    reg_sel_e         sel;
    logic             wr_status;
    logic             wr_enable;
    logic             soft_rst;
    logic [SRC_W-1:0] status_w;
    logic [SRC_W-1:0] enable_w;

    irq_bus_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SWRST_KEY(SWRST_KEY)
    ) u_decode (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .sel      (sel),
        .wr_status(wr_status),
        .wr_enable(wr_enable),
        .soft_rst (soft_rst)
    );

    irq_status_reg #(
        .NUM_IRQ(NUM_IRQ),
        .W      (SRC_W),
        .RST_VAL(STATUS_RST)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .wr      (wr_status),
        .wdata   (bus_wdata[SRC_W-1:0]),
        .src     (irq_src),
        .status  (status_w)
    );

    irq_enable_reg #(
        .NUM_IRQ(NUM_IRQ),
        .W      (SRC_W)
    ) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .wr      (wr_enable),
        .wdata   (bus_wdata[SRC_W-1:0]),
        .enable  (enable_w)
    );

    irq_combine #(
        .W(SRC_W)
    ) u_combine (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .status  (status_w),
        .enable  (enable_w),
        .irq_q   (irq_out)
    );

    // Combinational read mux; unmapped and write-only words read 0.
    always_comb begin
        case (sel)
            SEL_STATUS: bus_rdata = DATA_W'(status_w);
            SEL_ENABLE: bus_rdata = DATA_W'(enable_w);
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_reg_bank_chk.sv
`timescale 1ns/1ps
// Module: irq_reg_bank_chk
// Property checker for irq_reg_bank, attached by bind below.
module irq_reg_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int          NUM_IRQ   = 12,
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 4,
    parameter logic [31:0] SWRST_KEY = 32'h0000_00A5,
    parameter int          SRC_W     = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [SRC_W-1:0]  irq_src,
    input logic              irq_out,
    input logic [SRC_W-1:0]  status,
    input logic [SRC_W-1:0]  enable
);

    localparam logic [DATA_W-1:0] FULL_MASK = DATA_W'(low_mask(NUM_IRQ));
    localparam logic [SRC_W-1:0]  SRC_MASK  = SRC_W'(low_mask(NUM_IRQ));

    logic fire;
    logic en_write;
    assign fire     = bus_we && (bus_addr == ADDR_W'(OFS_SWRST)) &&
                      (bus_wdata == DATA_W'(SWRST_KEY));
    assign en_write = bus_we && (bus_addr == ADDR_W'(OFS_ENABLE));

    a_r1_enable_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (enable == '0));

    a_r8_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ((enable == '0) && !irq_out));

    a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (irq_out == $past(|(status & enable))));

    a_r4_event_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ((status & $past(irq_src) & SRC_MASK) == ($past(irq_src) & SRC_MASK)));

    a_r5_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_write && !fire) |=> $stable(enable));

    a_r7_absent_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata & ~FULL_MASK) == '0));

endmodule

bind irq_reg_bank irq_reg_bank_chk #(
    .NUM_IRQ  (NUM_IRQ),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .SWRST_KEY(SWRST_KEY),
    .SRC_W    (SRC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_src  (irq_src),
    .irq_out  (irq_out),
    .status   (status_w),
    .enable   (enable_w)
);

// File: tb/irq_reg_bank_tb.sv
`timescale 1ns/1ps
// Directed bench for irq_reg_bank with default parameters:
// NUM_IRQ=12, status reset 0x5, key 0xA5, status at word 0, enable at 1, reset word 2.
module irq_reg_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] irq_src = '0;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_reg_bank u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_src  (irq_src),
        .irq_out  (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One write cycle with optional concurrent hardware events; returns at the next falling edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [11:0] s);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; irq_src = s;
        @(negedge clk);
        bus_we = 1'b0; irq_src = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'd0, v); check("R2 status reset value", v, 32'h5);
        rd(4'd1, v); check("R1 enable reset value", v, 32'h0);
        check("R6 irq low after reset", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_toggle;
        logic [31:0] v;
        wr(4'd0, 32'h0F0, '0); rd(4'd0, v); check("R3 first write sets", v, 32'h0F5);
        wr(4'd0, 32'h0F0, '0); rd(4'd0, v); check("R3 second write clears", v, 32'h005);
        wr(4'd0, 32'h001, '0); rd(4'd0, v); check("R3 flip clears reset-set bit", v, 32'h004);
        wr(4'd0, 32'h001, '0); rd(4'd0, v); check("R3 flip restores bit", v, 32'h005);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        wr(4'd1, 32'hABC, '0); rd(4'd1, v); check("R5 enable readback", v, 32'hABC);
        wr(4'd1, 32'h000, '0); rd(4'd1, v); check("R5 enable readback zero", v, 32'h0);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wr(4'd1, 32'h008, '0);
        @(negedge clk);
        check("R6 no cause no irq", {31'b0, irq_out}, 32'h0);
        wr(4'd0, 32'h008, '0);
        check("R6 irq not yet raised", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R6 irq raised one cycle later", {31'b0, irq_out}, 32'h1);
        wr(4'd1, 32'h000, '0);
        check("R6 irq still high at disable edge", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R6 irq drops one cycle later", {31'b0, irq_out}, 32'h0);
        wr(4'd0, 32'h008, '0); rd(4'd0, v); check("R3 acknowledge bit 3", v, 32'h005);
    endtask

    task automatic t_hw;
        logic [31:0] v;
        @(negedge clk); irq_src = 12'h200;
        @(negedge clk); irq_src = '0;
        @(negedge clk);
        rd(4'd0, v); check("R4 event is sticky", v, 32'h205);
        wr(4'd0, 32'h200, '0); rd(4'd0, v); check("R4 event acknowledged", v, 32'h005);
        wr(4'd0, 32'h041, 12'h041); rd(4'd0, v); check("R4 event wins over flip", v, 32'h045);
        wr(4'd0, 32'h040, '0); rd(4'd0, v); check("R4 cleanup", v, 32'h005);
    endtask

    task automatic t_absent;
        logic [31:0] v;
        wr(4'd0, 32'hFFFF_F000, '0); rd(4'd0, v); check("R7 upper status bits ignored", v, 32'h005);
        wr(4'd1, 32'hFFFF_F000, '0); rd(4'd1, v); check("R7 upper enable bits ignored", v, 32'h000);
        rd(4'd3, v); check("R9 unmapped read zero", v, 32'h0);
        rd(4'd2, v); check("R9 reset word reads zero", v, 32'h0);
        wr(4'd3, 32'h0000_0FFF, '0);
        rd(4'd0, v); check("R9 unmapped write leaves status", v, 32'h005);
        rd(4'd1, v); check("R9 unmapped write leaves enable", v, 32'h000);
    endtask

    task automatic t_swrst;
        logic [31:0] v;
        wr(4'd1, 32'hFFF, '0);
        wr(4'd0, 32'h3A0, '0);
        @(negedge clk);
        check("R6 irq high before soft reset", {31'b0, irq_out}, 32'h1);
        wr(4'd2, 32'h5A, '0);
        rd(4'd0, v); check("R8 wrong key leaves status", v, 32'h3A5);
        rd(4'd1, v); check("R8 wrong key leaves enable", v, 32'hFFF);
        wr(4'd2, 32'hA5, 12'h200);
        check("R8 irq cleared at reset edge", {31'b0, irq_out}, 32'h0);
        rd(4'd0, v); check("R8 status back to reset, event dropped", v, 32'h005);
        rd(4'd1, v); check("R8 enable cleared", v, 32'h000);
        @(negedge clk);
        check("R8 irq stays low", {31'b0, irq_out}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_toggle();
        t_enable();
        t_irq();
        t_hw();
        t_absent();
        t_swrst();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule